// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block is a small memory-mapped window through which a host with a 64-bit register port reaches a separate internal register bus that has 13-bit addresses and 32-bit data. One host write to the control word carries a complete internal-bus transaction: the command, the target address and, for a write, the data. The bridge then runs that single read or write on the internal request/acknowledge bus. The host learns that the transaction has finished by polling a completion flag in a separate status word. The same status word returns the read data.

A read-only parameter word describes the serial engine that sits behind the internal bus: its shift order, word width, chip-select count, clock polarity, clock phase and a peripheral identifier. These values are fixed by parameters at build time. Only one transaction can be in flight at a time. The internal request is held high until it is acknowledged. Completion normally shows up within one or two host polls.

Top module: `regwin_bridge`

## Requirements
- R1: After a synchronous active-low reset, the control and status words both read as zero, and the internal request is low.
- R2: Offset 0x08 reads as the parameter word. Bit 0 is 0. Bit 1 is the shift order (1 = LSB first). Bits [7:2] hold the word width. Bits [13:8] hold the chip-select count. Bit 14 is clock polarity and bit 15 is clock phase. Bits [47:32] hold the peripheral ID. All other bits read 0.
- R3: Offset 0x10 reads back the last accepted control word. Its bits [31:0] are write data, bits [44:32] are the internal address and bits [63:62] are the command. The reserved bits [61:45] read as 0, whatever value was written to them.
- R4: Writing command 1 (read) while idle raises the internal request on the next cycle with the write strobe low and the address taken from bits [44:32]. The same write clears the status valid flag, which is bit 32 of the status word.
- R5: Writing command 2 (write) while idle raises the internal request on the next cycle with the write strobe high and the write data taken from bits [31:0].
- R6: While the request is high and unacknowledged, the request, address, write strobe and write data stay unchanged. The request falls in the cycle after the acknowledge.
- R7: On an acknowledge, the status valid flag (bit 32 at offset 0x18) is set on the next cycle. For a read, bits [31:0] of the status word capture the returned data at that same edge. A write leaves them unchanged.
- R8: Command 0 (no operation) and command 3 (reserved) start no internal transaction and leave the status word unchanged. They still update the control readback.
- R9: A control write made while a transaction is in flight is ignored. The control readback and the running transaction both keep the original command.
- R10: Host writes to offsets 0x08 and 0x18, and to any unmapped offset, change nothing. Unmapped offsets read as 0, and status bits [63:33] read as 0.
- R11: An acknowledge that arrives while no transaction is in flight has no effect on the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | ADDR_W | Host byte offset |
| hst_wr_en | input | 1 | Host write strobe, one cycle per write |
| hst_wdata | input | 64 | Host write data |
| hst_rdata | output | 64 | Host read data for hst_addr (combinational) |
| ib_req | output | 1 | Internal bus request, held until acknowledged |
| ib_we | output | 1 | Internal bus write strobe (1 = write) |
| ib_addr | output | 13 | Internal bus address |
| ib_wdata | output | 32 | Internal bus write data |
| ib_ack | input | 1 | Internal bus acknowledge |
| ib_rdata | input | 32 | Internal bus read data, valid with ib_ack |

## Verification
Host reads are combinational, so a read result is due in the same cycle as its address. A control write that is sampled at a clock edge shows up in the control readback, on the internal request and as a cleared valid flag just after that edge. The acknowledge sampled at an edge shows up as a set valid flag, captured read data and a dropped request just after that edge. The bench drives every input on the falling edge. It steps a behavioural model on the rising edge and compares all outputs with that model one time unit after each falling edge, once every result has settled. The acknowledge latency ranges from zero to several cycles.

// File: rtl/regwin_pkg.sv
// Shared types and constants for the indirect register access bridge.
// Assumes the control-word field positions are fixed; only the parameter
// word contents vary between builds.
package regwin_pkg;

    localparam int IB_AW = 13;
    localparam int IB_DW = 32;

    localparam int OFS_PARAM = 8'h08;
    localparam int OFS_CTRL  = 8'h10;
    localparam int OFS_STAT  = 8'h18;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [IB_AW-1:0] addr;
        logic [IB_DW-1:0] data;
    } ctrl_t;

endpackage

// File: rtl/regwin_ctrl_reg.sv
// Control word register: captures host writes to the control offset while
// the engine is idle and flags when a read or write command is accepted.
// Assumes hst_wr_en is a single-cycle strobe; reserved bits are dropped.
module regwin_ctrl_reg
    import regwin_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_wr_en,
    input  logic [63:0]       hst_wdata,
    input  logic              busy,
    output ctrl_t             ctrl_q,
    output logic              start
);

    logic  accept;
    ctrl_t ctrl_d;
    logic  rsv_unused;

    // Decode a control write that may be taken now.
    always_comb begin
        accept = hst_wr_en && (hst_addr == ADDR_W'(OFS_CTRL)) && !busy;
        ctrl_d.op   = op_e'(hst_wdata[63:62]);
        ctrl_d.addr = hst_wdata[32 +: IB_AW];
        ctrl_d.data = hst_wdata[IB_DW-1:0];
        start  = accept && ((ctrl_d.op == OP_READ) || (ctrl_d.op == OP_WRITE));
    end

    assign rsv_unused = ^hst_wdata[61:45];

    // Hold the last accepted control word.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (accept) ctrl_q <= ctrl_d;
    end

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && hst_wr_en && (hst_addr == ADDR_W'(OFS_CTRL)) |=> $stable(ctrl_q)); // R9

endmodule

// File: rtl/regwin_txn_engine.sv
// Single-transaction engine: raises the internal request on a start, holds
// it until acknowledge, then sets the completion flag and latches read data.
// Assumes ctrl is frozen while busy (guaranteed by the control register).
module regwin_txn_engine
    import regwin_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  ctrl_t            ctrl,
    input  logic             ib_ack,
    input  logic [IB_DW-1:0] ib_rdata,
    output logic             busy,
    output logic             sts_valid,
    output logic [IB_DW-1:0] sts_rdata,
    output logic             ib_req,
    output logic             ib_we,
    output logic [IB_AW-1:0] ib_addr,
    output logic [IB_DW-1:0] ib_wdata
);

    logic done;

    // Completion happens only on an acknowledge to a live request.
    assign done = busy && ib_ack;

    // Track the in-flight state and the completion flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            sts_valid <= 1'b0;
        end else if (done) begin
            busy      <= 1'b0;
            sts_valid <= 1'b1;
        end else if (start) begin
            busy      <= 1'b1;
            sts_valid <= 1'b0;
        end
    end

    // Latch read data at the acknowledge of a read.
    always_ff @(posedge clk) begin
        if (!rst_n)                            sts_rdata <= '0;
        else if (done && ctrl.op == OP_READ)   sts_rdata <= ib_rdata;
    end

    // Drive the internal bus from the frozen control word.
    always_comb begin
        ib_req   = busy;
        ib_we    = (ctrl.op == OP_WRITE);
        ib_addr  = ctrl.addr;
        ib_wdata = ctrl.data;
    end

    AST_START_RAISES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ib_req && !sts_valid); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && !ib_ack |=> ib_req && $stable(ib_addr) && $stable(ib_we) && $stable(ib_wdata)); // R6
    AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && ib_ack |=> !ib_req && sts_valid); // R7
    AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req && ib_ack && ib_we |=> $stable(sts_rdata)); // R7
    AST_IDLE_STATUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ib_req && !start |=> $stable(sts_valid) && $stable(sts_rdata)); // R11

endmodule

// File: rtl/regwin_read_mux.sv
// Host read path: selects the parameter, control or status word by offset.
// Assumes combinational read; unmapped offsets return zero.
module regwin_read_mux
    import regwin_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter bit          LSB_FIRST  = 1'b0,
    parameter int          WORD_BITS  = 32,
    parameter int          NUM_SEL    = 1,
    parameter bit          CLK_POL    = 1'b0,
    parameter bit          CLK_PHA    = 1'b0,
    parameter logic [15:0] PERIPH_ID  = 16'h0000
) (
    input  logic [ADDR_W-1:0] hst_addr,
    input  ctrl_t             ctrl,
    input  logic              sts_valid,
    input  logic [IB_DW-1:0]  sts_rdata,
    output logic [63:0]       hst_rdata
);

    localparam logic [63:0] PARAM_WORD = {16'h0000, PERIPH_ID, 16'h0000,
                                          CLK_PHA, CLK_POL, 6'(NUM_SEL),
                                          6'(WORD_BITS), LSB_FIRST, 1'b0};

    logic [63:0] ctrl_word;
    logic [63:0] stat_word;

    // Assemble readable images of the live registers.
    always_comb begin
        ctrl_word = {ctrl.op, 17'd0, ctrl.addr, ctrl.data};
        stat_word = {31'd0, sts_valid, sts_rdata};
    end

    // Select by offset.
    always_comb begin
        case (hst_addr)
            ADDR_W'(OFS_PARAM): hst_rdata = PARAM_WORD;
            ADDR_W'(OFS_CTRL):  hst_rdata = ctrl_word;
            ADDR_W'(OFS_STAT):  hst_rdata = stat_word;
            default:            hst_rdata = 64'd0;
        endcase
    end

endmodule

// File: rtl/regwin_bridge.sv
// Indirect register access bridge top: 64-bit host window onto a 32-bit
// request/acknowledge register bus, one transaction at a time.
// Assumes the internal bus holds ib_rdata valid in the acknowledge cycle.
module regwin_bridge
    import regwin_pkg::*;
#(
    parameter int          ADDR_W     = 5,
    parameter bit          LSB_FIRST  = 1'b0,
    parameter int          WORD_BITS  = 32,
    parameter int          NUM_SEL    = 1,
    parameter bit          CLK_POL    = 1'b0,
    parameter bit          CLK_PHA    = 1'b0,
    parameter logic [15:0] PERIPH_ID  = 16'h0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] hst_addr,
    input  logic              hst_wr_en,
    input  logic [63:0]       hst_wdata,
    output logic [63:0]       hst_rdata,
    output logic              ib_req,
    output logic              ib_we,
    output logic [12:0]       ib_addr,
    output logic [31:0]       ib_wdata,
    input  logic              ib_ack,
    input  logic [31:0]       ib_rdata
);

    ctrl_t            ctrl_q;
    logic             start;
    logic             busy;
    logic             sts_valid;
    logic [IB_DW-1:0] sts_rdata;

    regwin_ctrl_reg #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr_en(hst_wr_en),
        .hst_wdata(hst_wdata), .busy(busy), .ctrl_q(ctrl_q), .start(start)
    );

    regwin_txn_engine u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl(ctrl_q),
        .ib_ack(ib_ack), .ib_rdata(ib_rdata), .busy(busy),
        .sts_valid(sts_valid), .sts_rdata(sts_rdata), .ib_req(ib_req),
        .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata)
    );

    regwin_read_mux #(
        .ADDR_W(ADDR_W), .LSB_FIRST(LSB_FIRST), .WORD_BITS(WORD_BITS),
        .NUM_SEL(NUM_SEL), .CLK_POL(CLK_POL), .CLK_PHA(CLK_PHA),
        .PERIPH_ID(PERIPH_ID)
    ) u_rmux (
        .hst_addr(hst_addr), .ctrl(ctrl_q), .sts_valid(sts_valid),
        .sts_rdata(sts_rdata), .hst_rdata(hst_rdata)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !ib_req); // R1
    AST_NO_VALID_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        ib_req |-> !hst_rdata[32] || hst_addr != ADDR_W'(OFS_STAT)); // R4

endmodule

// File: tb/regwin_bridge_bench.sv
module regwin_bridge_bench;

    localparam int HALF = 5;
    localparam int PERIOD = 2 * HALF;
    localparam logic [63:0] CMASK = 64'hC000_1FFF_FFFF_FFFF;
    localparam logic [63:0] EXP_PARAM =
        {16'h0000, 16'h5A17, 16'h0000, 1'b0, 1'b1, 6'd3, 6'd24, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  hst_addr = 5'h00;
    logic        hst_wr_en = 1'b0;
    logic [63:0] hst_wdata = '0;
    logic [63:0] hst_rdata;
    logic        ib_req, ib_we;
    logic [12:0] ib_addr;
    logic [31:0] ib_wdata;
    logic        ib_ack = 1'b0;
    logic [31:0] ib_rdata = '0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int ack_delay = 0;
    int wait_cnt = 0;
    int txn_seen = 0;
    bit force_ack = 1'b0;
    bit run_done = 1'b0;

    // reference model state
    bit          m_busy = 0;
    bit          m_valid = 0;
    logic [31:0] m_rdata = '0;
    logic [63:0] m_ctrl = '0;

    always #HALF clk = ~clk;

    regwin_bridge #(
        .ADDR_W(5), .LSB_FIRST(1'b1), .WORD_BITS(24), .NUM_SEL(3),
        .CLK_POL(1'b1), .CLK_PHA(1'b0), .PERIPH_ID(16'h5A17)
    ) u_regwin_bridge (
        .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_wr_en(hst_wr_en),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .ib_req(ib_req),
        .ib_we(ib_we), .ib_addr(ib_addr), .ib_wdata(ib_wdata),
        .ib_ack(ib_ack), .ib_rdata(ib_rdata)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model, stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_valid = 0; m_rdata = '0; m_ctrl = '0;
        end else if (m_busy && ib_ack) begin
            m_busy = 0; m_valid = 1;
            if (m_ctrl[63:62] == 2'd1) m_rdata = ib_rdata;
        end else if (!m_busy && hst_wr_en && hst_addr == 5'h10) begin
            m_ctrl = hst_wdata & CMASK;
            if (m_ctrl[63:62] == 2'd1 || m_ctrl[63:62] == 2'd2) begin
                m_busy = 1; m_valid = 0;
            end
        end
    end

    function automatic logic [63:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h08:   return EXP_PARAM;
            5'h10:   return m_ctrl;
            5'h18:   return {31'd0, m_valid, m_rdata};
            default: return 64'd0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [4:0] a);
        case (a)
            5'h08:   return "R2 param word";
            5'h10:   return "R3 control readback";
            5'h18:   return "R7 status word";
            default: return "R10 unmapped read";
        endcase
    endfunction

    // per-cycle compare, after inputs and outputs have settled
    always @(negedge clk) begin
        #1;
        if (rst_n && !run_done) begin
            check(hst_rdata === exp_rd(hst_addr), rd_tag(hst_addr), hst_rdata, exp_rd(hst_addr));
            check(ib_req === m_busy, "R4 request level", 64'(ib_req), 64'(m_busy));
            if (m_busy) begin
                check(ib_we === (m_ctrl[63:62] == 2'd2), "R5 write strobe", 64'(ib_we),
                      64'(m_ctrl[63:62] == 2'd2));
                check(ib_addr === m_ctrl[44:32], "R6 address", 64'(ib_addr), 64'(m_ctrl[44:32]));
                check(ib_wdata === m_ctrl[31:0], "R6 write data", 64'(ib_wdata), 64'(m_ctrl[31:0]));
            end
        end
    end

    // internal bus responder
    always @(negedge clk) begin
        if (force_ack) begin
            ib_ack <= 1'b1;
        end else if (ib_req && !ib_ack) begin
            if (wait_cnt >= ack_delay) begin
                txn_seen++;
                ib_ack   <= 1'b1;
                ib_rdata <= 32'hC0DE_0000 + 32'(txn_seen);
            end else begin
                wait_cnt++;
            end
        end else begin
            ib_ack   <= 1'b0;
            wait_cnt = 0;
        end
    end

    task automatic host_wr(input logic [4:0] a, input logic [63:0] d);
        @(negedge clk);
        hst_wr_en = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr_en = 1'b0;
    endtask

    task automatic expect_rd(input logic [4:0] a, input logic [63:0] exp, input string tag);
        hst_addr = a;
        @(negedge clk);
        #2;
        check(hst_rdata === exp, tag, hst_rdata, exp);
    endtask

    task automatic wait_done();
        hst_addr = 5'h18;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            #2;
            if (hst_rdata[32]) break;
        end
    endtask

    initial begin
        logic [31:0] last_rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        expect_rd(5'h10, 64'd0, "R1 control after reset");
        expect_rd(5'h18, 64'd0, "R1 status after reset");
        check(ib_req === 1'b0, "R1 request after reset", 64'(ib_req), 64'd0);
        // R2: parameter layout
        expect_rd(5'h08, EXP_PARAM, "R2 param word");
        // R4: read command with reserved bits set, ack after 2 cycles
        ack_delay = 2;
        host_wr(5'h10, {2'b01, 17'h1FFFF, 13'h1ABC, 32'hDEAD_BEEF});
        #2;
        check(ib_req === 1'b1 && ib_we === 1'b0, "R4 read request raised",
              64'({ib_req, ib_we}), 64'b10);
        check(ib_addr === 13'h1ABC, "R4 read address", 64'(ib_addr), 64'h1ABC);
        expect_rd(5'h10, {2'b01, 17'd0, 13'h1ABC, 32'hDEAD_BEEF}, "R3 reserved bits read zero");
        expect_rd(5'h18, 64'd0, "R4 valid cleared while busy");
        wait_done();
        check(hst_rdata === {31'd0, 1'b1, 32'hC0DE_0001}, "R7 read completion",
              hst_rdata, {31'd0, 1'b1, 32'hC0DE_0001});
        last_rd = hst_rdata[31:0];
        // R5: write command, ack at once
        ack_delay = 0;
        host_wr(5'h10, {2'b10, 17'd0, 13'h0042, 32'h1234_5678});
        #2;
        check(ib_req === 1'b1 && ib_we === 1'b1 && ib_wdata === 32'h1234_5678,
              "R5 write request", {31'd0, ib_req, ib_we, ib_wdata}, {31'd0, 2'b11, 32'h1234_5678});
        wait_done();
        check(hst_rdata === {31'd0, 1'b1, last_rd}, "R7 write keeps read data",
              hst_rdata, {31'd0, 1'b1, last_rd});
        // R9: second command while busy is ignored
        ack_delay = 5;
        host_wr(5'h10, {2'b01, 17'd0, 13'h0F0F, 32'h0});
        host_wr(5'h10, {2'b10, 17'd0, 13'h1111, 32'hFFFF_0000});
        #2;
        check(ib_addr === 13'h0F0F && ib_we === 1'b0, "R9 busy write ignored",
              64'({ib_we, ib_addr}), 64'h0F0F);
        expect_rd(5'h10, {2'b01, 17'd0, 13'h0F0F, 32'h0}, "R9 control readback kept");
        wait_done();
        check(hst_rdata === {31'd0, 1'b1, 32'hC0DE_0003}, "R9 original read completes",
              hst_rdata, {31'd0, 1'b1, 32'hC0DE_0003});
        // R8: no-op and reserved commands
        host_wr(5'h10, {2'b00, 17'd0, 13'h0777, 32'hAAAA_5555});
        #2;
        check(ib_req === 1'b0, "R8 no-op starts nothing", 64'(ib_req), 64'd0);
        expect_rd(5'h18, {31'd0, 1'b1, 32'hC0DE_0003}, "R8 no-op keeps status");
        expect_rd(5'h10, {2'b00, 17'd0, 13'h0777, 32'hAAAA_5555}, "R8 no-op readback");
        host_wr(5'h10, {2'b11, 17'd0, 13'h0001, 32'h0});
        repeat (2) @(negedge clk);
        check(ib_req === 1'b0, "R8 reserved command starts nothing", 64'(ib_req), 64'd0);
        expect_rd(5'h18, {31'd0, 1'b1, 32'hC0DE_0003}, "R8 reserved keeps status");
        // R11: stray acknowledge while idle
        @(negedge clk);
        force_ack = 1'b1;
        ib_rdata = 32'hBAD0_BAD0;
        repeat (3) @(negedge clk);
        force_ack = 1'b0;
        expect_rd(5'h18, {31'd0, 1'b1, 32'hC0DE_0003}, "R11 stray ack ignored");
        // R10: writes to read-only and unmapped offsets
        host_wr(5'h08, 64'hFFFF_FFFF_FFFF_FFFF);
        host_wr(5'h18, 64'd0);
        host_wr(5'h04, {2'b01, 62'd0});
        expect_rd(5'h08, EXP_PARAM, "R10 param unchanged");
        expect_rd(5'h18, {31'd0, 1'b1, 32'hC0DE_0003}, "R10 status unchanged");
        expect_rd(5'h04, 64'd0, "R10 unmapped reads zero");
        check(ib_req === 1'b0, "R10 unmapped write starts nothing", 64'(ib_req), 64'd0);
        // back-to-back reads with varied latency
        for (int k = 0; k < 4; k++) begin
            ack_delay = k;
            host_wr(5'h10, {2'b01, 17'd0, 13'(k * 13'h0101), 32'd0});
            wait_done();
            check(hst_rdata[32] === 1'b1, "R7 completion with latency", hst_rdata, 64'h1_0000_0000);
        end
        repeat (3) @(negedge clk);
        run_done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !run_done) begin
            run_done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R6 watchdog expired actual=%0d expected=<20000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule